// File: doc/BRIEF.md
# Instruction Prefix Scanner

This block sits at the front of a decoder for a variable-length legacy instruction set. It takes the instruction stream one byte per cycle over a valid/ready handshake. It takes in the prefix bytes that come before an opcode and records what each one asks for:
- a segment override,
- an operand-size or address-size flip,
- a bus lock,
- one of two repeat forms.

The first byte that is not a prefix is captured as the opcode, together with its position in the instruction. From that point the prefix state is frozen.

The opcode also refines the recorded prefixes. After a short conditional jump opcode, the two override codes that double as static branch hints become a hint and stop being a segment override. After a string opcode, the destination segment is pinned to ES whatever override is present.

A length guard counts every accepted byte, including bytes after the opcode that a later stage consumes. It raises a fault when an instruction grows past the architectural maximum. While the fault is up the block stops accepting bytes. An external end-of-instruction pulse, driven by whatever decodes the body, returns the block to its empty state.

Top module: `pfx_scan`

## Requirements
- R1: A synchronous active-high reset clears all state. After reset there is no override (`seg_ovr`=0), `seg_src` and `seg_dst` are both 3 (DS), all flags are 0, `rep_mode`=0, `br_hint`=0, `opc_valid`=0, `opc_idx`=0, `len_fault`=0 and `in_ready`=1.
- R2: The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64 and 0x65 set `seg_ovr`=1. Each sets `seg_src` to its code: ES=0 for 0x26, CS=1 for 0x2E, SS=2 for 0x36, DS=3 for 0x3E, FS=4 for 0x64 and GS=5 for 0x65. When several overrides appear, the last one wins. With no override, `seg_src` is 3.
- R3: Byte 0x66 sets `opsz_flip` and byte 0x67 sets `adsz_flip`. Repeating either byte has the same effect as giving it once.
- R4: Byte 0xF0 sets `lock_flag`. Byte 0xF2 sets `rep_mode`=1 and byte 0xF3 sets `rep_mode`=2, with the later of the two winning.
- R5: The first accepted byte that is not one of the prefix codes above is the opcode. The cycle after it is accepted, `opc_valid`=1 and `opc_byte` holds that byte. `opc_idx` gives its 0-based position, which equals the number of prefixes before it.
- R6: Once `opc_valid` is 1, further bytes, including bytes equal to prefix codes, change no prefix output, no opcode output and `opc_idx` until `insn_end`.
- R7: When the opcode is 0x70..0x7F and the last segment prefix was 0x3E, `br_hint`=1 (taken). When it was 0x2E, `br_hint`=2 (not taken). In both cases `seg_ovr` returns to 0. Any other last override on such an opcode stays an override with `br_hint`=0.
- R8: For the string opcodes 0xA4..0xA7, 0xAA..0xAF and 0x6C..0x6F, `seg_dst` is 0 (ES) whatever overrides came before, while `seg_src` follows R2. For any other opcode, `seg_dst` equals `seg_src`.
- R9: The cycle after the instruction's accepted byte count first exceeds MAX_LEN (15), `len_fault` is 1. It stays 1 until `insn_end`. While it is 1, `in_ready` is 0 and offered bytes are not taken.
- R10: `insn_end` clears all prefix, opcode, length and fault state. A byte accepted in the same cycle is the first byte of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte offered |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| insn_end | input | 1 | Current instruction is finished |
| seg_src | output | 3 | Source / single-operand segment code |
| seg_dst | output | 3 | Destination segment code |
| seg_ovr | output | 1 | A segment override is in force |
| opsz_flip | output | 1 | Operand size toggled |
| adsz_flip | output | 1 | Address size toggled |
| lock_flag | output | 1 | Lock requested |
| rep_mode | output | 2 | 0 none, 1 repeat-while-not-equal, 2 repeat / while-equal |
| br_hint | output | 2 | 0 none, 1 taken, 2 not taken |
| opc_valid | output | 1 | Opcode byte has been seen |
| opc_idx | output | 5 | 0-based position of the opcode byte |
| opc_byte | output | 8 | Captured opcode byte |
| len_fault | output | 1 | Length limit exceeded |

## Verification
Two functions can fall in the same cycle.

The first is the end-of-instruction clear arriving together with an accepted byte. The bench provokes it by raising `insn_end` alongside the first byte of a new instruction. It then judges that the old flags are gone while the new prefix counts from position 0.

The second is the length fault arriving on the very byte that is itself a prefix. Sixteen prefix bytes are streamed. The bench expects the fault and the sixteenth prefix's flag together, still with no opcode. A byte offered afterwards while ready is low must leave every output untouched.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [2:0] {
    SEG_ES = 3'd0, SEG_CS = 3'd1, SEG_SS = 3'd2,
    SEG_DS = 3'd3, SEG_FS = 3'd4, SEG_GS = 3'd5
  } seg_e;

  typedef enum logic [1:0] {
    REP_NONE = 2'd0, REP_NE = 2'd1, REP_EQ = 2'd2
  } rep_e;

  typedef enum logic [1:0] {
    HINT_NONE = 2'd0, HINT_TAKEN = 2'd1, HINT_NOT = 2'd2
  } hint_e;

  typedef enum logic [2:0] {
    BK_OPC, BK_SEG, BK_OPSZ, BK_ADSZ, BK_LOCK, BK_REP
  } bkind_e;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify
  import pfx_pkg::*;
(
  input  logic [7:0] byte_i,
  output bkind_e     kind,
  output seg_e       seg,
  output rep_e       rep,
  output logic       is_jcc,
  output logic       is_str
);
  always_comb begin
    kind = BK_OPC;
    seg  = SEG_DS;
    rep  = REP_NONE;
    unique case (byte_i)
      8'h26: begin kind = BK_SEG; seg = SEG_ES; end
      8'h2E: begin kind = BK_SEG; seg = SEG_CS; end
      8'h36: begin kind = BK_SEG; seg = SEG_SS; end
      8'h3E: begin kind = BK_SEG; seg = SEG_DS; end
      8'h64: begin kind = BK_SEG; seg = SEG_FS; end
      8'h65: begin kind = BK_SEG; seg = SEG_GS; end
      8'h66: kind = BK_OPSZ;
      8'h67: kind = BK_ADSZ;
      8'hF0: kind = BK_LOCK;
      8'hF2: begin kind = BK_REP; rep = REP_NE; end
      8'hF3: begin kind = BK_REP; rep = REP_EQ; end
      default: kind = BK_OPC;
    endcase
  end

  // short conditional jumps occupy one aligned block of sixteen codes
  assign is_jcc = (byte_i[7:4] == 4'h7);

  // string moves/compares, store/load/scan, and port string transfers
  assign is_str = (byte_i[7:2] == 6'b101001) ||
                  (byte_i >= 8'hAA && byte_i <= 8'hAF) ||
                  (byte_i[7:2] == 6'b011011);
endmodule

// File: rtl/pfx_len_guard.sv
module pfx_len_guard #(
  parameter int MAX_LEN = 15,
  parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [LEN_W-1:0] cnt,
  output logic             fault
);
  localparam logic [LEN_W-1:0] SAT = LEN_W'(MAX_LEN + 1);

  logic [LEN_W-1:0] base, nxt;

  always_comb begin
    base = clr ? '0 : cnt;
    if (step && base != SAT) nxt = base + 1'b1;
    else                     nxt = base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      cnt   <= nxt;
      fault <= (nxt > LEN_W'(MAX_LEN));
    end
  end
endmodule

// File: rtl/pfx_scan.sv
module pfx_scan #(
  parameter int MAX_LEN = 15,
  parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  input  logic             insn_end,
  output logic [2:0]       seg_src,
  output logic [2:0]       seg_dst,
  output logic             seg_ovr,
  output logic             opsz_flip,
  output logic             adsz_flip,
  output logic             lock_flag,
  output logic [1:0]       rep_mode,
  output logic [1:0]       br_hint,
  output logic             opc_valid,
  output logic [LEN_W-1:0] opc_idx,
  output logic [7:0]       opc_byte,
  output logic             len_fault
);
  import pfx_pkg::*;

  bkind_e           c_kind;
  seg_e             c_seg;
  rep_e             c_rep;
  logic             c_jcc, c_str;
  logic [LEN_W-1:0] len_cnt;
  logic             fault_q;

  seg_e  ovr_seg_q;
  rep_e  rep_q;
  hint_e hint_q;
  logic  ovr_q, opsz_q, adsz_q, lock_q, opcv_q, str_q;
  logic [LEN_W-1:0] idx_q;
  logic [7:0]       opb_q;

  logic             accept, scanning, base_ovr;
  logic [LEN_W-1:0] base_cnt;

  pfx_classify u_cls (
    .byte_i (in_byte),
    .kind   (c_kind),
    .seg    (c_seg),
    .rep    (c_rep),
    .is_jcc (c_jcc),
    .is_str (c_str)
  );

  pfx_len_guard #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_len (
    .clk   (clk),
    .rst   (rst),
    .clr   (insn_end),
    .step  (accept),
    .cnt   (len_cnt),
    .fault (fault_q)
  );

  assign in_ready = ~fault_q;
  assign accept   = in_valid & in_ready;
  assign scanning = insn_end | ~opcv_q;
  assign base_ovr = ovr_q & ~insn_end;
  assign base_cnt = insn_end ? '0 : len_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0; ovr_seg_q <= SEG_DS; opsz_q <= 1'b0; adsz_q <= 1'b0;
      lock_q <= 1'b0; rep_q <= REP_NONE; hint_q <= HINT_NONE;
      opcv_q <= 1'b0; idx_q <= '0; opb_q <= '0; str_q <= 1'b0;
    end else begin
      if (insn_end) begin
        ovr_q <= 1'b0; ovr_seg_q <= SEG_DS; opsz_q <= 1'b0; adsz_q <= 1'b0;
        lock_q <= 1'b0; rep_q <= REP_NONE; hint_q <= HINT_NONE;
        opcv_q <= 1'b0; idx_q <= '0; opb_q <= '0; str_q <= 1'b0;
      end
      if (accept && scanning) begin
        unique case (c_kind)
          BK_SEG:  begin ovr_q <= 1'b1; ovr_seg_q <= c_seg; end
          BK_OPSZ: opsz_q <= 1'b1;
          BK_ADSZ: adsz_q <= 1'b1;
          BK_LOCK: lock_q <= 1'b1;
          BK_REP:  rep_q  <= c_rep;
          default: begin
            opcv_q <= 1'b1;
            opb_q  <= in_byte;
            idx_q  <= base_cnt;
            str_q  <= c_str;
            if (c_jcc && base_ovr && ovr_seg_q == SEG_DS) begin
              hint_q <= HINT_TAKEN;
              ovr_q  <= 1'b0;
            end else if (c_jcc && base_ovr && ovr_seg_q == SEG_CS) begin
              hint_q <= HINT_NOT;
              ovr_q  <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign seg_ovr   = ovr_q;
  assign seg_src   = ovr_q ? ovr_seg_q : SEG_DS;
  assign seg_dst   = str_q ? SEG_ES : seg_src;
  assign opsz_flip = opsz_q;
  assign adsz_flip = adsz_q;
  assign lock_flag = lock_q;
  assign rep_mode  = rep_q;
  assign br_hint   = hint_q;
  assign opc_valid = opcv_q;
  assign opc_idx   = idx_q;
  assign opc_byte  = opb_q;
  assign len_fault = fault_q;
endmodule

// File: rtl/pfx_scan_chk.sv
module pfx_scan_chk #(
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          insn_end,
  input logic [2:0]    seg_src,
  input logic [2:0]    seg_dst,
  input logic          seg_ovr,
  input logic          opsz_flip,
  input logic          adsz_flip,
  input logic          lock_flag,
  input logic [1:0]    rep_mode,
  input logic [1:0]    br_hint,
  input logic          opc_valid,
  input logic [IW-1:0] opc_idx,
  input logic [7:0]    opc_byte,
  input logic          len_fault
);
  logic str_opc;
  assign str_opc = (opc_byte[7:2] == 6'b101001) ||
                   (opc_byte >= 8'hAA && opc_byte <= 8'hAF) ||
                   (opc_byte[7:2] == 6'b011011);

  // R9
  fault_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(len_fault) |-> $past(in_valid && in_ready));

  // R5
  opc_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(opc_valid) |-> $past(in_valid && in_ready));

  // R6
  frozen_body_chk: assert property (@(posedge clk) disable iff (rst)
    (opc_valid && !insn_end) |=> ($stable(opsz_flip) && $stable(adsz_flip) &&
      $stable(lock_flag) && $stable(rep_mode) && $stable(seg_src) &&
      $stable(opc_byte) && $stable(opc_idx) && $stable(br_hint)));

  // R8
  str_dst_es_chk: assert property (@(posedge clk) disable iff (rst)
    (opc_valid && str_opc) |-> (seg_dst == 3'd0));

  // R7
  hint_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (br_hint != 2'd0) |-> (!seg_ovr && opc_valid));

  // R10
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (insn_end && !in_valid) |=> (!opc_valid && !seg_ovr && !lock_flag &&
      !len_fault && rep_mode == 2'd0 && !opsz_flip && !adsz_flip));
endmodule

bind pfx_scan pfx_scan_chk #(.IW(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .insn_end(insn_end), .seg_src(seg_src), .seg_dst(seg_dst),
  .seg_ovr(seg_ovr), .opsz_flip(opsz_flip), .adsz_flip(adsz_flip),
  .lock_flag(lock_flag), .rep_mode(rep_mode), .br_hint(br_hint),
  .opc_valid(opc_valid), .opc_idx(opc_idx), .opc_byte(opc_byte),
  .len_fault(len_fault)
);

// File: tb/pfx_scan_test.sv
`timescale 1ns/1ps
module pfx_scan_test;
  localparam int MAXL = 15;
  localparam int IW   = $clog2(MAXL + 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic insn_end = 1'b0;
  logic in_ready, seg_ovr, opsz_flip, adsz_flip, lock_flag, opc_valid, len_fault;
  logic [2:0] seg_src, seg_dst;
  logic [1:0] rep_mode, br_hint;
  logic [IW-1:0] opc_idx;
  logic [7:0] opc_byte;

  always #10 clk = ~clk;

  pfx_scan #(.MAX_LEN(MAXL)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .insn_end(insn_end), .seg_src(seg_src),
    .seg_dst(seg_dst), .seg_ovr(seg_ovr), .opsz_flip(opsz_flip),
    .adsz_flip(adsz_flip), .lock_flag(lock_flag), .rep_mode(rep_mode),
    .br_hint(br_hint), .opc_valid(opc_valid), .opc_idx(opc_idx),
    .opc_byte(opc_byte), .len_fault(len_fault)
  );

  typedef struct {
    string tag;
    int src, dst, ovr, osz, asz, lck, rep, hnt, ov, idx, ob, flt, rdy;
  } exp_t;

  exp_t sb[$];
  event chk_ev;
  logic [7:0] stim[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
    end
  endtask

  // independent reference built from the requirement text
  function automatic exp_t model(input string tag);
    exp_t e;
    int seg;
    e.tag = tag; e.ovr = 0; seg = 3; e.osz = 0; e.asz = 0; e.lck = 0;
    e.rep = 0; e.hnt = 0; e.ov = 0; e.idx = 0; e.ob = 0; e.dst = 0;
    for (int i = 0; i < stim.size(); i++) begin
      if (e.ov == 0) begin
        case (stim[i])
          8'h26: begin e.ovr = 1; seg = 0; end
          8'h2E: begin e.ovr = 1; seg = 1; end
          8'h36: begin e.ovr = 1; seg = 2; end
          8'h3E: begin e.ovr = 1; seg = 3; end
          8'h64: begin e.ovr = 1; seg = 4; end
          8'h65: begin e.ovr = 1; seg = 5; end
          8'h66: e.osz = 1;
          8'h67: e.asz = 1;
          8'hF0: e.lck = 1;
          8'hF2: e.rep = 1;
          8'hF3: e.rep = 2;
          default: begin
            e.ov = 1; e.idx = i; e.ob = int'(stim[i]);
            if (stim[i] >= 8'h70 && stim[i] <= 8'h7F && e.ovr == 1 && (seg == 3 || seg == 1)) begin
              e.hnt = (seg == 3) ? 1 : 2;
              e.ovr = 0;
            end
          end
        endcase
      end
    end
    e.src = e.ovr ? seg : 3;
    if (e.ov == 1 && ((e.ob >= 'hA4 && e.ob <= 'hA7) || (e.ob >= 'hAA && e.ob <= 'hAF) ||
                      (e.ob >= 'h6C && e.ob <= 'h6F)))
      e.dst = 0;
    else
      e.dst = e.src;
    e.flt = (stim.size() > MAXL) ? 1 : 0;
    e.rdy = 1 - e.flt;
    return e;
  endfunction

  // monitor: pops expected items and compares with the outputs
  always @(chk_ev) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk("R2", e.tag, int'(seg_src), e.src);
      chk("R2", e.tag, int'(seg_ovr), e.ovr);
      chk("R8", e.tag, int'(seg_dst), e.dst);
      chk("R3", e.tag, int'(opsz_flip), e.osz);
      chk("R3", e.tag, int'(adsz_flip), e.asz);
      chk("R4", e.tag, int'(lock_flag), e.lck);
      chk("R4", e.tag, int'(rep_mode), e.rep);
      chk("R7", e.tag, int'(br_hint), e.hnt);
      chk("R5", e.tag, int'(opc_valid), e.ov);
      chk("R5", e.tag, int'(opc_idx), e.idx);
      chk("R5", e.tag, int'(opc_byte), e.ob);
      chk("R9", e.tag, int'(len_fault), e.flt);
      chk("R9", e.tag, int'(in_ready), e.rdy);
    end
  end

  // driver: streams stim, pushes the expected item, optionally ends the instruction
  task automatic run(input string tag, input bit merge, input bit end_after);
    for (int i = 0; i < stim.size(); i++) begin
      in_valid = 1'b1;
      in_byte  = stim[i];
      insn_end = (i == 0) && merge;
      @(negedge clk);
    end
    in_valid = 1'b0;
    insn_end = 1'b0;
    sb.push_back(model(tag));
    ->chk_ev;
    #1;
    if (end_after) begin
      insn_end = 1'b1;
      @(negedge clk);
      insn_end = 1'b0;
    end
  endtask

  task automatic expect_empty(input string tag);
    stim = {};
    sb.push_back(model(tag));
    ->chk_ev;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_empty("R1 reset state");

    stim = {8'h90};                         run("R5 bare opcode", 0, 1);
    stim = {8'h2E, 8'h66, 8'hF3, 8'hA5};    run("R8 string with CS", 0, 1);
    stim = {8'h64, 8'hAE};                  run("R8 scan with FS", 0, 1);
    stim = {8'h26, 8'h64, 8'h36, 8'h8B};    run("R2 last override wins", 0, 1);
    stim = {8'h65, 8'h89};                  run("R2 GS plain", 0, 1);
    stim = {8'h66, 8'h66, 8'h67, 8'h67, 8'hF2, 8'hF3, 8'hF2, 8'h01};
    run("R3 R4 repeats", 0, 1);
    stim = {8'hF0, 8'hF3, 8'h87};           run("R4 lock rep", 0, 1);
    stim = {8'h3E, 8'h74};                  run("R7 hint taken", 0, 1);
    stim = {8'h2E, 8'h75};                  run("R7 hint not taken", 0, 1);
    stim = {8'h65, 8'h7F};                  run("R7 GS stays override", 0, 1);
    stim = {8'h2E, 8'h3E, 8'h70};           run("R7 last of two hints", 0, 1);
    stim = {8'h3E, 8'h8B};                  run("R7 DS on non-jump", 0, 1);
    stim = {8'h88, 8'hF0, 8'h66, 8'h26, 8'hF3}; run("R6 body bytes ignored", 0, 1);
    expect_empty("R10 cleared by end");

    // R10: end merged with first byte of the next instruction
    stim = {8'h67, 8'h26, 8'h90};           run("R10 before merge", 0, 0);
    stim = {8'hF0, 8'h90};                  run("R10 merged end", 1, 1);

    // R9: exactly the limit, prefixes then opcode
    stim = {};
    for (int i = 0; i < MAXL - 1; i++) stim.push_back(8'h66);
    stim.push_back(8'h90);                  run("R9 at limit", 0, 1);
    // R9: one past the limit, last byte is a prefix
    stim = {};
    for (int i = 0; i < MAXL; i++) stim.push_back(8'h66);
    stim.push_back(8'hF0);                  run("R9 over limit", 0, 0);
    // R9: byte offered while not ready must not be taken
    in_valid = 1'b1; in_byte = 8'h67;
    @(negedge clk);
    in_valid = 1'b0;
    sb.push_back(model("R9 blocked byte"));
    ->chk_ev;
    #1;
    insn_end = 1'b1; @(negedge clk); insn_end = 1'b0;
    expect_empty("R9 R10 fault cleared");
    // R9: long body after opcode
    stim = {8'h90};
    for (int i = 0; i < MAXL; i++) stim.push_back(8'h00);
    run("R9 long body", 0, 1);

    // R1: reset in the middle of an instruction
    stim = {8'hF0, 8'h26};                  run("R1 before reset", 0, 0);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    expect_empty("R1 reset mid-instruction");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule